// File: doc/BRIEF.md
# Programmable Flag Threshold Register Port

This block holds the two threshold values that a FIFO's programmable flags are compared against: one for the almost-empty flag and one for the almost-full flag. Both are loaded through the FIFO's own write data bus. When the active-low load strobe is held low, each write-enabled clock edge writes the low 12 bits of the data bus into one of the two thresholds. A read-enabled edge copies a threshold onto a 12-bit read-back bus instead.

One selector decides which threshold each access reaches. It alternates between the two on every qualified access, whether that access is a write or a read. The selector keeps its position when the strobe goes high. A load that stops partway therefore carries on with the other threshold the next time the strobe is lowered. Reset restores the depth-dependent default values and points the selector back at the almost-empty threshold.

The write side and the read side use one clock here, so the shared selector never crosses a clock domain. There is no data stream in this block. Every pin is a plain level-sampled control or a data bus, with no valid/ready handshake and no back-pressure.

Top module: `flag_offset_port`

## Requirements
- R1: After reset (`rst_n` low), `ae_ofs` and `af_ofs` both equal the default for parameter `DEPTH`, `rdback` is zero, and the selector points at the almost-empty threshold.
- R2: The default threshold is 0x01F when `DEPTH` is 256 or less, 0x03F when `DEPTH` is 257 to 512, and 0x07F for larger depths.
- R3: A rising edge with `load_n`=0 and `wen_n`=0 writes `din[11:0]` into the selected threshold. The new value appears on `ae_ofs` or `af_ofs` after that edge.
- R4: Consecutive qualified accesses go to the almost-empty threshold first, then the almost-full threshold, then the almost-empty threshold again, and so on.
- R5: An edge with `load_n`=0 and both enables high changes neither threshold, `rdback` nor the selector.
- R6: While `load_n`=1, `wen_n` and `ren_n` have no effect on the thresholds, `rdback` or the selector.
- R7: The selector keeps its position while `load_n` is high. Lowering the strobe again resumes with the threshold that follows the last one accessed.
- R8: A rising edge with `load_n`=0 and `ren_n`=0 loads the selected threshold onto `rdback` and advances the selector.
- R9: `rdback` changes only on a qualified read edge and holds its value at every other edge.
- R10: Bits of `din` above bit 11 never reach a threshold.
- R11: When a qualified write and a qualified read fall on the same edge, both go to the same threshold. `rdback` gets the value from before the write, and the selector advances once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared write/read clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_n | input | 1 | Threshold access strobe, active low |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| din | input | DATA_W (18) | FIFO write data; bits 11..0 feed the thresholds |
| ae_ofs | output | 12 | Almost-empty threshold value |
| af_ofs | output | 12 | Almost-full threshold value |
| rdback | output | 12 | Read-back of the threshold selected at the last qualified read |

## Verification
The assertions assume that `load_n`, `wen_n`, `ren_n` and `din` are driven to known levels and settle well before each rising edge. They also assume that checking starts only once reset has been released for a full cycle.

The stimulus changes inputs only on the falling clock edge. It mixes directed sequences with seeded random cycles. The random cycles hold the strobe low most of the time so that both thresholds and the read-back path are exercised, and they set the upper data bits freely.

// File: rtl/flag_offset_pkg.sv
package flag_offset_pkg;

  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } ofs_sel_e;

  // Depth-dependent reset value of both thresholds
  function automatic logic [11:0] ofs_default(input int depth);
    if (depth <= 256)      return 12'h01F;
    else if (depth <= 512) return 12'h03F;
    else                   return 12'h07F;
  endfunction

endpackage

// File: rtl/offset_seq.sv
module offset_seq
  import flag_offset_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step,
  output ofs_sel_e sel
);

  ofs_sel_e sel_q;
  logic     armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= SEL_AE;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (step) sel_q <= (sel_q == SEL_AE) ? SEL_AF : SEL_AE;
    end
  end

  assign sel = sel_q;

  // R4
  sel_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && step |=> sel != $past(sel));

  // R7
  sel_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && !step |=> $stable(sel));

endmodule

// File: rtl/offset_regs.sv
module offset_regs
  import flag_offset_pkg::*;
#(
  parameter int          OFS_W = 12,
  parameter logic [11:0] RST_V = 12'h03F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  ofs_sel_e         sel,
  input  logic [OFS_W-1:0] wdata,
  output logic [OFS_W-1:0] ae_o,
  output logic [OFS_W-1:0] af_o
);

  localparam int NREG = 2;

  logic [OFS_W-1:0] ofs_q [NREG];
  logic             armed_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                           ofs_q[g] <= OFS_W'(RST_V);
      else if (wr && (int'(sel) == g))      ofs_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign ae_o = ofs_q[0];
  assign af_o = ofs_q[1];

  // R3
  ae_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && wr && sel == SEL_AE |=> ae_o == $past(wdata) && $stable(af_o));

  // R3
  af_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && wr && sel == SEL_AF |=> af_o == $past(wdata) && $stable(ae_o));

  // R5
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && !wr |=> $stable(ae_o) && $stable(af_o));

endmodule

// File: rtl/offset_readback.sv
module offset_readback
  import flag_offset_pkg::*;
#(
  parameter int OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd,
  input  ofs_sel_e         sel,
  input  logic [OFS_W-1:0] ae_i,
  input  logic [OFS_W-1:0] af_i,
  output logic [OFS_W-1:0] rdback
);

  logic [OFS_W-1:0] rb_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_q    <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (rd) rb_q <= (sel == SEL_AF) ? af_i : ae_i;
    end
  end

  assign rdback = rb_q;

  // R9
  rdback_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && !rd |=> $stable(rdback));

  // R8
  rdback_ae_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && rd && sel == SEL_AE |=> rdback == $past(ae_i));

endmodule

// File: rtl/flag_offset_port.sv
module flag_offset_port
  import flag_offset_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              wen_n,
  input  logic              ren_n,
  input  logic [DATA_W-1:0] din,
  output logic [11:0]       ae_ofs,
  output logic [11:0]       af_ofs,
  output logic [11:0]       rdback
);

  localparam int          OFS_W = 12;
  localparam logic [11:0] RST_V = ofs_default(DEPTH);

  logic     wr_q, rd_q, step;
  ofs_sel_e sel;

  assign wr_q = !load_n && !wen_n;
  assign rd_q = !load_n && !ren_n;
  assign step = wr_q || rd_q;

  offset_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .sel   (sel)
  );

  // R10: only the low OFS_W data bits reach the thresholds
  offset_regs #(.OFS_W(OFS_W), .RST_V(RST_V)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_q),
    .sel   (sel),
    .wdata (din[OFS_W-1:0]),
    .ae_o  (ae_ofs),
    .af_o  (af_ofs)
  );

  offset_readback #(.OFS_W(OFS_W)) u_rb (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd     (rd_q),
    .sel    (sel),
    .ae_i   (ae_ofs),
    .af_i   (af_ofs),
    .rdback (rdback)
  );

  logic armed_q;
  always_ff @(posedge clk) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R6
  strobe_high_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && load_n |=> $stable(ae_ofs) && $stable(af_ofs) && $stable(rdback));

  // R11
  same_edge_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && wr_q && rd_q && sel == SEL_AF |=> rdback == $past(af_ofs));

endmodule

// File: tb/test_flag_offset_port.sv
module test_flag_offset_port;

  localparam int DEPTH  = 512;
  localparam int DATA_W = 18;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load_n = 1'b1, wen_n = 1'b1, ren_n = 1'b1;
  logic [DATA_W-1:0] din = '0;
  logic [11:0]       ae_ofs, af_ofs, rdback;

  int n_chk = 0;
  int n_fail = 0;

  // expected-state model
  logic [11:0] m_ae, m_af, m_rb;
  logic        m_ptr;

  always #2.5 clk = ~clk;

  flag_offset_port #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_flag_offset_port (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .wen_n(wen_n), .ren_n(ren_n),
    .din(din), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .rdback(rdback)
  );

  function automatic logic [11:0] exp_default(input int depth);
    if (depth <= 256) return 12'h01F;
    if (depth <= 512) return 12'h03F;
    return 12'h07F;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "ae_ofs", ae_ofs, m_ae);
    check(req, "af_ofs", af_ofs, m_af);
    check(req, "rdback", rdback, m_rb);
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic ld, input logic we, input logic re,
                      input logic [DATA_W-1:0] d, input string req);
    load_n = ld; wen_n = we; ren_n = re; din = d;
    @(posedge clk);
    if (!ld) begin
      if (!re) m_rb = m_ptr ? m_af : m_ae;
      if (!we) begin
        if (m_ptr) m_af = d[11:0];
        else       m_ae = d[11:0];
      end
      if (!we || !re) m_ptr = ~m_ptr;
    end
    @(negedge clk);
    load_n = 1'b1; wen_n = 1'b1; ren_n = 1'b1;
    check_all(req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_ae = exp_default(DEPTH); m_af = exp_default(DEPTH);
    m_rb = '0; m_ptr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // R1 R2: reset state, default 0x03F for DEPTH=512
    check("R1", "ae_ofs", ae_ofs, 12'h03F);
    check("R2", "af_ofs", af_ofs, 12'h03F);
    check("R1", "rdback", rdback, 12'h000);

    // R3 R4: AE, AF, AE again
    step(1'b0, 1'b0, 1'b1, 18'h00111, "R3");
    check("R3", "ae after first write", ae_ofs, 12'h111);
    step(1'b0, 1'b0, 1'b1, 18'h00222, "R4");
    check("R4", "af after second write", af_ofs, 12'h222);
    step(1'b0, 1'b0, 1'b1, 18'h00333, "R4");
    check("R4", "ae after third write", ae_ofs, 12'h333);

    // R5: strobe low, both enables high
    step(1'b0, 1'b1, 1'b1, 18'h00FFF, "R5");
    // R6: strobe high, ordinary FIFO write/read
    step(1'b1, 1'b0, 1'b0, 18'h00ABC, "R6");
    check("R6", "af unchanged", af_ofs, 12'h222);
    // R7: pointer now at AF, resumes there
    step(1'b0, 1'b0, 1'b1, 18'h00444, "R7");
    check("R7", "af after resume", af_ofs, 12'h444);

    // R8: read back AE then AF
    step(1'b0, 1'b1, 1'b0, '0, "R8");
    check("R8", "rdback ae", rdback, 12'h333);
    step(1'b0, 1'b1, 1'b0, '0, "R8");
    check("R8", "rdback af", rdback, 12'h444);
    // R9: hold on non-read edges
    step(1'b0, 1'b0, 1'b1, 18'h00555, "R9");
    check("R9", "rdback held", rdback, 12'h444);

    // R10: upper data bits ignored (pointer at AF now)
    step(1'b0, 1'b0, 1'b1, 18'h3F666, "R10");
    check("R10", "af low bits only", af_ofs, 12'h666);

    // R11: simultaneous read and write on AE (old value 0x555)
    step(1'b0, 1'b0, 1'b0, 18'h00777, "R11");
    check("R11", "rdback old ae", rdback, 12'h555);
    check("R11", "ae new", ae_ofs, 12'h777);
    step(1'b0, 1'b1, 1'b0, '0, "R11");
    check("R11", "single advance to af", rdback, 12'h666);

    // reset mid-way returns pointer to AE (R1)
    do_reset();
    check_all("R1");
    step(1'b0, 1'b1, 1'b0, '0, "R1");
    check("R1", "pointer at ae after reset", rdback, 12'h03F);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic ld, we, re;
      ld = ($urandom_range(0, 3) == 0);
      we = $urandom_range(0, 1) == 1;
      re = $urandom_range(0, 1) == 1;
      step(ld, we, re, DATA_W'($urandom), "R3/R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule